// File: doc/BRIEF.md
# Clock Source Select and Peripheral Prescaler

This block makes the system clock and the peripheral clock taps for a small microcontroller. Every clock is modelled as a one-cycle enable pulse on a single fast reference clock. Two oscillator tick inputs, one from the main oscillator or external clock path and one from an internal oscillator, arrive as single-cycle pulses. A configuration bit picks one of them. That choice is captured while reset is held and is then fixed for the whole run.

The chosen ticks pass through a divide-by-two stage, which produces the system clock enable. Because the stage counts ticks, the shape of the input waveform does not matter. The system clock enable then drives a binary prescaler. The prescaler raises tap n once every 2^n system clock pulses, for n from 0 to 12, so the slowest tap divides by 4096. A stop request freezes the prescaler count and holds every tap low. When the request is released, counting carries on from the held value.

Top module: `clkgen_top`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, the block clears its toggle and its prescaler count. At that edge `sys_clk_en` and all bits of `tap_en` go to 0.
- R2: `cfg_src` is captured at each edge where `rst_n` is low. Value 0 selects `main_tick` and value 1 selects `int_tick`. Ticks on the source that is not selected have no effect on any output.
- R3: A change of `cfg_src` while `rst_n` is high has no effect on which source is used.
- R4: `sys_clk_en` is high for exactly one cycle, in the cycle after the edge at which the 2nd, 4th, 6th and so on selected tick after reset is sampled. This holds whatever the spacing of the ticks.
- R5: When `stop_req` is low, `tap_en[0]` is high in the cycle after each `sys_clk_en` pulse.
- R6: When no stop occurs, `tap_en[n]` goes high on the k·2^n-th `sys_clk_en` pulse after reset, for every k ≥ 1. It goes high one cycle after that pulse. So `tap_en[12]` first goes high after the 4096th pulse.
- R7: If `stop_req` is high at an edge, every `tap_en` bit is 0 after that edge. A `sys_clk_en` pulse that lands during the stop does not advance the prescaler count. After release, the tap sequence continues from the held count.
- R8: `stop_req` has no effect on `sys_clk_en`.
- R9: Whenever `tap_en[n]` is high, every lower tap `tap_en[m]` with m < n is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also captures `cfg_src` |
| cfg_src | input | 1 | Source choice: 0 = main oscillator path, 1 = internal oscillator |
| main_tick | input | 1 | One-cycle pulse per main oscillator or external clock period |
| int_tick | input | 1 | One-cycle pulse per internal oscillator period |
| stop_req | input | 1 | High to freeze the prescaler and hold all taps low |
| sys_clk_en | output | 1 | System clock enable, one pulse per two selected ticks |
| tap_en | output | 13 | Peripheral tap enables; bit n pulses once per 2^n system pulses |

## Verification
The main oscillator is first driven with a tick on every cycle, while the internal input carries a different pattern as noise. This separates a correct source choice from a leaked one, and a long enough run reaches the divide-by-4096 tap. The internal source is then selected and driven with sparse ticks and with bursty ticks. This shows that the halving counts ticks rather than following the waveform shape. The source bit is flipped after reset to check that the captured choice holds. Stop is applied as both a long hold and a fast toggle, to show that the count is held and resumes rather than being lost or reset.

// File: rtl/clkgen_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the clock source and prescaler block.
// Assumes a single reference clock; oscillator edges arrive as tick pulses.
package clkgen_pkg;

    // Source encoding captured from the configuration bit during reset.
    typedef enum logic {
        SRC_MAIN     = 1'b0,
        SRC_INTERNAL = 1'b1
    } clk_src_e;

    // Default number of peripheral taps (divide ratios 2^0 .. 2^(N-1)).
    localparam int unsigned DEFAULT_TAPS = 13;

endpackage

// File: rtl/clkgen_src_mux.sv
`timescale 1ns/1ps
// Module: source selector.
// Captures the configuration bit on every edge where reset is asserted,
// then routes the chosen oscillator tick. Assumes ticks are 1-cycle pulses.
module clkgen_src_mux
    import clkgen_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_src,
    input  logic     main_tick,
    input  logic     int_tick,
    output logic     sel_tick,
    output clk_src_e src_q
);

    // Purpose: latch the source choice only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= clk_src_e'(cfg_src);
        end
    end

    // Purpose: forward the tick of the captured source.
    always_comb begin
        sel_tick = (src_q == SRC_INTERNAL) ? int_tick : main_tick;
    end

endmodule

// File: rtl/clkgen_div2.sv
`timescale 1ns/1ps
// Module: divide-by-two stage.
// Counts selected ticks and emits one registered pulse per two ticks, so the
// result is independent of the input waveform's high/low balance.
module clkgen_div2 (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic sys_en
);

    logic phase_q;

    // Purpose: flip the phase on each tick and pulse on every second tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            sys_en  <= 1'b0;
        end else begin
            sys_en <= tick & phase_q;
            if (tick) begin
                phase_q <= ~phase_q;
            end
        end
    end

endmodule

// File: rtl/clkgen_prescaler.sv
`timescale 1ns/1ps
// Module: binary prescaler with NUM_TAPS registered tap enables.
// Tap n pulses on every 2^n-th input pulse. A stop request holds the count
// and forces all taps low. Assumes NUM_TAPS >= 2.
module clkgen_prescaler #(
    parameter int unsigned NUM_TAPS = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_en,
    input  logic                stop_req,
    output logic [NUM_TAPS-1:0] tap_en
);

    localparam int unsigned CNT_W = NUM_TAPS - 1;

    logic [CNT_W-1:0]    count_q;
    logic [NUM_TAPS-1:0] tap_d;

    // Purpose: decode each tap from the low-order ones of the count.
    generate
        for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
            if (g == 0) begin : g_first
                assign tap_d[g] = in_en;
            end else begin : g_rest
                assign tap_d[g] = in_en & (&count_q[g-1:0]);
            end
        end
    endgenerate

    // Purpose: advance the count on each input pulse unless stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (in_en && !stop_req) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    // Purpose: register the tap enables, gated by the stop request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_en <= '0;
        end else begin
            tap_en <= stop_req ? '0 : tap_d;
        end
    end

endmodule

// File: rtl/clkgen_top.sv
`timescale 1ns/1ps
// Module: clock source select, divide-by-two and peripheral prescaler.
// All derived clocks are enable pulses on clk. The source is fixed at reset.
module clkgen_top
    import clkgen_pkg::*;
#(
    parameter int unsigned NUM_TAPS = DEFAULT_TAPS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_src,
    input  logic                main_tick,
    input  logic                int_tick,
    input  logic                stop_req,
    output logic                sys_clk_en,
    output logic [NUM_TAPS-1:0] tap_en
);

    logic     sel_tick;
    clk_src_e src_q;

    clkgen_src_mux u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_src   (cfg_src),
        .main_tick (main_tick),
        .int_tick  (int_tick),
        .sel_tick  (sel_tick),
        .src_q     (src_q)
    );

    clkgen_div2 u_div2 (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (sel_tick),
        .sys_en (sys_clk_en)
    );

    clkgen_prescaler #(
        .NUM_TAPS (NUM_TAPS)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_en    (sys_clk_en),
        .stop_req (stop_req),
        .tap_en   (tap_en)
    );

endmodule

// File: rtl/clkgen_checker.sv
`timescale 1ns/1ps
// Module: assertion checker bound into clkgen_top.
module clkgen_checker
    import clkgen_pkg::*;
#(
    parameter int unsigned NUM_TAPS = DEFAULT_TAPS
) (
    input logic                clk,
    input logic                rst_n,
    input logic                stop_req,
    input logic                sel_tick,
    input clk_src_e            src_q,
    input logic                sys_clk_en,
    input logic [NUM_TAPS-1:0] tap_en
);

    logic was_in_reset = 1'b0;

    // Purpose: remember whether reset was applied at the previous edge.
    always_ff @(posedge clk) begin
        was_in_reset <= !rst_n;
    end

    // Purpose: outputs are quiet after a reset edge (R1).
    always @(posedge clk) begin
        if (was_in_reset) begin
            assert_quiet_after_reset_R1: assert (sys_clk_en == 1'b0 && tap_en == '0)
                else $error("outputs active after reset edge");
        end
    end

    assert_source_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(src_q));

    assert_sys_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_clk_en |-> $past(sel_tick));

    assert_sys_not_back_to_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_clk_en |=> !sys_clk_en);

    assert_tap0_follows_sys_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tap_en[0] |-> ($past(sys_clk_en) && !$past(stop_req)));

    assert_stop_silences_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_req) |-> (tap_en == '0));

    assert_taps_nested_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((tap_en + NUM_TAPS'(1)) & tap_en) == '0);

endmodule

bind clkgen_top clkgen_checker #(.NUM_TAPS(NUM_TAPS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_req   (stop_req),
    .sel_tick   (sel_tick),
    .src_q      (src_q),
    .sys_clk_en (sys_clk_en),
    .tap_en     (tap_en)
);

// File: tb/clkgen_top_test.sv
`timescale 1ns/1ps
module clkgen_top_test;

    localparam int NT   = 13;
    localparam int WRAP = 1 << (NT - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_src = 1'b0;
    logic          main_tick = 1'b0;
    logic          int_tick = 1'b0;
    logic          stop_req = 1'b0;
    logic          sys_clk_en;
    logic [NT-1:0] tap_en;

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string sys_tag = "R1";
    string tap_tag = "R1";

    // behavioural reference state
    int            m_src = 0;
    int            m_phase = 0;
    int            m_count = 0;
    logic          m_sys = 1'b0;
    logic [NT-1:0] m_tap = '0;

    always #2.5 clk = ~clk;

    clkgen_top #(.NUM_TAPS(NT)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_src    (cfg_src),
        .main_tick  (main_tick),
        .int_tick   (int_tick),
        .stop_req   (stop_req),
        .sys_clk_en (sys_clk_en),
        .tap_en     (tap_en)
    );

    task automatic model_edge();
        logic sel;
        if (!rst_n) begin
            m_src = int'(cfg_src);
            m_phase = 0; m_count = 0; m_sys = 1'b0; m_tap = '0;
        end else begin
            sel = (m_src == 1) ? int_tick : main_tick;
            if (m_sys && !stop_req) begin
                for (int n = 0; n < NT; n++)
                    m_tap[n] = ((m_count % (1 << n)) == ((1 << n) - 1));
                m_count = (m_count + 1) % WRAP;
            end else begin
                m_tap = '0;
            end
            m_sys = sel && (m_phase == 1);
            if (sel) m_phase = 1 - m_phase;
        end
    endtask

    task automatic compare();
        checks++;
        if (sys_clk_en !== m_sys) begin
            errors++;
            $display("FAIL %s sys_clk_en actual=%b expected=%b t=%0t", sys_tag, sys_clk_en, m_sys, $time);
        end
        checks++;
        if (tap_en !== m_tap) begin
            errors++;
            $display("FAIL %s tap_en actual=%h expected=%h t=%0t", tap_tag, tap_en, m_tap, $time);
        end
        checks++;
        if (((tap_en + NT'(1)) & tap_en) != '0) begin // R9 nesting
            errors++;
            $display("FAIL R9 tap_en not nested actual=%h expected low-order ones", tap_en);
        end
    endtask

    task automatic cycle(input logic mt, input logic it, input logic st);
        main_tick = mt; int_tick = it; stop_req = st;
        @(posedge clk);
        model_edge();
        #1;
        compare();
    endtask

    initial begin
        // R1: reset with main source chosen, ticks present
        rst_n = 0; cfg_src = 0;
        for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1, 1'b0);
        // R4/R5: main ticks every cycle, internal noise
        rst_n = 1; sys_tag = "R4"; tap_tag = "R5";
        for (int i = 0; i < 200; i++) cycle(1'b1, logic'(i % 2), 1'b0);
        // R3: configuration bit flips after reset
        cfg_src = 1; sys_tag = "R3"; tap_tag = "R3";
        for (int i = 0; i < 300; i++) cycle(1'b1, logic'(i % 3 == 0), 1'b0);
        // R6: long run reaching the slowest tap
        sys_tag = "R4"; tap_tag = "R6";
        for (int i = 0; i < 8600; i++) cycle(1'b1, 1'b0, 1'b0);
        // R7/R8: long stop, resume, then fast toggling stop
        sys_tag = "R8"; tap_tag = "R7";
        for (int i = 0; i < 40; i++) cycle(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 100; i++) cycle(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 300; i++) cycle(1'b1, 1'b0, logic'((i / 7) % 2));
        // R1/R2: reset selecting the internal source
        rst_n = 0; cfg_src = 1; sys_tag = "R1"; tap_tag = "R1";
        for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, 1'b0);
        rst_n = 1; sys_tag = "R2"; tap_tag = "R2";
        for (int i = 0; i < 600; i++) cycle(1'b1, logic'(i % 3 == 0), 1'b0);
        // R4: bursty internal ticks (uneven duty)
        sys_tag = "R4"; tap_tag = "R5";
        for (int i = 0; i < 600; i++) cycle(logic'(i % 2), logic'(i % 5 < 2), 1'b0);
        // R2: back to main source with irregular ticks, internal always high
        rst_n = 0; cfg_src = 0; sys_tag = "R1"; tap_tag = "R1";
        for (int i = 0; i < 2; i++) cycle(1'b0, 1'b1, 1'b0);
        rst_n = 1; sys_tag = "R2"; tap_tag = "R2";
        for (int i = 0; i < 600; i++) cycle(logic'(i % 4 != 1), 1'b1, logic'(i % 50 > 44));
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog R1..all actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule